// File: doc/BRIEF.md
# Serial 1010 Pattern Detector (Moore)

This block watches a single serial data bit, sampled on each rising clock edge, and raises a flag when the four most recent bits form the pattern 1, 0, 1, 0 (the first of these received first). The flag is decoded from the present state alone, through a dedicated hit state. Because of this, it appears in the cycle after the edge that samples the final 0 of a match. It never responds to the data input between edges.

A mode input chooses between two ways of counting matches. In overlapping mode, the trailing "10" of one match can serve as the leading "10" of the next. In non-overlapping mode, the search starts afresh after each hit. The mode input is read on every edge, but it only affects the transition taken out of the hit state.

The states are IDLE (nothing matched), GOT1 ("1" matched), GOT10 ("10" matched), GOT101 ("101" matched) and HIT (the full pattern was seen, detect high). The transitions are:
- IDLE: 1 goes to GOT1, 0 stays in IDLE.
- GOT1: 1 stays in GOT1, 0 goes to GOT10.
- GOT10: 1 goes to GOT101, 0 goes to IDLE.
- GOT101: 0 goes to HIT, 1 falls back to GOT1.
- HIT: 0 goes to IDLE in either mode. 1 goes to GOT101 in overlapping mode and to GOT1 in non-overlapping mode.
- Any unused encoding returns to IDLE.

Top module: `seq_pattern_det`

## Requirements
- R1: A synchronous, active-high `rst` sampled at a rising edge puts the machine in IDLE. `detect` is then low in the following cycle, and any partial match gathered before the reset is discarded.
- R2: When the edge samples the final 0 of the bit sequence 1,0,1,0, `detect` is high for exactly the one cycle that follows that edge, provided the mode rules in R5 and R6 count the match.
- R3: `detect` depends only on the state. A change of `din` between clock edges does not change `detect`.
- R4: On a mismatching bit, the machine falls back to the deepest partial match the received bits still support. For example, "11" stays in GOT1, "1011" returns to GOT1 so that a following "010" completes a hit, and "100" returns to IDLE.
- R5: With `ovl_mode`=1, overlapping matches are counted. The stream 11010101011 gives hits after bits 5, 7 and 9.
- R6: With `ovl_mode`=0, each hit restarts the search. The stream 11010101011 gives hits after bits 5 and 9 only.
- R7: `ovl_mode` has an effect only on the bit that immediately follows a hit. Changing it at any other time does not alter which matches are reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to IDLE |
| din | input | 1 | Serial data bit, one per clock |
| ovl_mode | input | 1 | 1 = overlapping matches counted, 0 = restart the search after each hit |
| detect | output | 1 | High for one cycle after a counted match |

## Verification
The embedded assertions check on every cycle that `detect` never lasts two cycles, that each pulse is preceded by a sampled 0 out of GOT101, that reset leaves `detect` low, and that the successor of HIT matches the mode in force. Only the bench scenarios can show that whole streams produce hits at the right positions: the fallback paths, the two counting styles on the same stream, mode changes away from a hit, a reset in the middle of a match, and `detect` holding still while `din` toggles between edges.

// File: rtl/spd_pkg.sv
package spd_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        IDLE   = 3'd0,
        GOT1   = 3'd1,
        GOT10  = 3'd2,
        GOT101 = 3'd3,
        HIT    = 3'd4
    } spd_state_e;
endpackage

// File: rtl/spd_next_state.sv
module spd_next_state
    import spd_pkg::*;
(
    input  spd_state_e cur,
    input  logic       bit_in,
    input  logic       ovl,
    output spd_state_e nxt
);
    always_comb begin
        unique case (cur)
            IDLE:    nxt = bit_in ? GOT1 : IDLE;
            GOT1:    nxt = bit_in ? GOT1 : GOT10;
            GOT10:   nxt = bit_in ? GOT101 : IDLE;
            GOT101:  nxt = bit_in ? GOT1 : HIT;
            HIT: begin
                if (!bit_in)   nxt = IDLE;
                else if (ovl)  nxt = GOT101;
                else           nxt = GOT1;
            end
            default: nxt = IDLE;
        endcase
    end
endmodule

// File: rtl/spd_out_decode.sv
module spd_out_decode
    import spd_pkg::*;
(
    input  spd_state_e cur,
    output logic       hit
);
    always_comb begin
        unique case (cur)
            HIT:     hit = 1'b1;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq_pattern_det.sv
module seq_pattern_det
    import spd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic ovl_mode,
    output logic detect
);
    spd_state_e state_q;
    spd_state_e state_d;

    spd_next_state u_next (
        .cur    (state_q),
        .bit_in (din),
        .ovl    (ovl_mode),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= IDLE;
        else     state_q <= state_d;
    end

    spd_out_decode u_out (
        .cur (state_q),
        .hit (detect)
    );

    // R1: the cycle after a reset edge shows no detection
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !detect);

    // R2: a pulse lasts a single cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        detect |=> !detect);

    // R2: a pulse is preceded by a sampled 0 taken out of GOT101
    a_r2_final_zero: assert property (@(posedge clk) disable iff (rst)
        (detect && !$past(rst)) |-> ($past(state_q) == GOT101 && !$past(din)));

    // R5: overlapping mode continues a match from the hit state
    a_r5_overlap_chain: assert property (@(posedge clk) disable iff (rst)
        (detect && ovl_mode && din) |=> (state_q == GOT101));

    // R6: non-overlapping mode restarts after a hit
    a_r6_fresh_start: assert property (@(posedge clk) disable iff (rst)
        (detect && !ovl_mode) |=> (state_q == GOT1 || state_q == IDLE));
endmodule

// File: tb/seq_pattern_det_tb.sv
module seq_pattern_det_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic ovl_mode = 1'b0;
    logic detect;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit exp_q[$];
    string tag_q[$];

    logic [3:0] hist = 4'b0;
    int since_hit = 4;

    always #5 clk = ~clk;

    seq_pattern_det u_dut (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .ovl_mode (ovl_mode),
        .detect   (detect)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: detect=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: apply one bit and predict detect from a history model
    task automatic send(input bit b, input bit m, input bit r, input string tag);
        bit e;
        @(negedge clk);
        din = b;
        ovl_mode = m;
        rst = r;
        if (r) begin
            hist = 4'b0;
            since_hit = 4;
            e = 1'b0;
        end else begin
            hist = {hist[2:0], b};
            if (since_hit == 0 && m) since_hit = 4;
            else if (since_hit < 4) since_hit++;
            e = (hist == 4'b1010) && (since_hit >= 4);
            if (e) since_hit = 0;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic send_str(input string s, input bit m, input string tag);
        for (int i = 0; i < s.len(); i++) send(s[i] == "1", m, 1'b0, tag);
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() != 0) begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, detect, e);
        end
    end

    initial begin
        send(1'b0, 1'b0, 1'b1, "R1");
        send(1'b1, 1'b0, 1'b1, "R1");
        send_str("11010101011", 1'b1, "R5");
        send(1'b0, 1'b0, 1'b1, "R1");
        send_str("11010101011", 1'b0, "R6");
        send(1'b0, 1'b0, 1'b1, "R1");
        send_str("1101011010", 1'b0, "R4");
        send_str("100100110", 1'b1, "R4");
        // R2: a lone match, then R3: toggling din while detect is high
        send_str("0001010", 1'b0, "R2");
        @(posedge clk);
        #3;
        din = ~din;
        #1;
        check("R3", detect, 1'b1);
        din = ~din;
        #0.5;
        check("R3", detect, 1'b1);
        send_str("000", 1'b0, "R2");
        // R7: mode flipped away from the bit after a hit
        send_str("1010", 1'b0, "R7");
        send(1'b1, 1'b1, 1'b0, "R7");
        send(1'b0, 1'b0, 1'b0, "R7");
        send_str("1", 1'b1, "R7");
        send(1'b0, 1'b0, 1'b0, "R7");
        send_str("10", 1'b1, "R7");
        send_str("1010", 1'b1, "R7");
        send(1'b1, 1'b0, 1'b0, "R7");
        send(1'b0, 1'b1, 1'b0, "R7");
        send_str("10", 1'b1, "R7");
        // R1: reset in the middle of a match
        send_str("101", 1'b1, "R1");
        send(1'b0, 1'b1, 1'b1, "R1");
        send_str("0", 1'b1, "R1");
        send_str("1010", 1'b1, "R1");
        send(1'b0, 1'b0, 1'b0, "R1");
        @(posedge clk);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule